// File: doc/BRIEF.md
# Banked Video Card Bus Decoder

This block sits between an 8-bit backplane bus with a 64K memory space and the video card behind it. On I/O cycles it compares the I/O address against a configurable base and claims a group of four consecutive ports. It reports which of the four was addressed so that neighbouring logic can act on it. The first port of the group is a combined bank-select register. That register gathers the video RAM bank, the character ROM and colour plane selects, the dot clock choice and the window enable into one byte.

On memory cycles the block opens a 4K window at F000h–FFFFh onto a 32K video RAM. The three bank bits of the register supply the upper RAM address bits. The bus memory-expansion line is handled in one of two configured ways. In output mode the card drives the line to a configured level during each cycle that hits the window, so that other memory on the bus can step aside. In input mode the card never drives the line, and it enables its own RAM only when the line is sampled high. All outputs are registered and change one clock after the bus cycle that causes them.

Top module: `vidcard_bus_decode`

## Requirements
- R1: A synchronous active-high reset clears the bank register to 00h and drives port_sel, win_hit, ram_en and xl_oe low.
- R2: An I/O cycle (iorq high) whose addr[7:2] equals base_cfg raises bit addr[1:0] of port_sel, and only that bit, on the following clock. addr[15:8] play no part in the compare.
- R3: An I/O cycle whose addr[7:2] differs from base_cfg, or any cycle with iorq low, leaves port_sel at zero on the following clock.
- R4: A write (iorq and wr high) to port index 0 of the group loads wdata into bank_q on the following clock. Writes to indices 1 to 3, I/O reads, missed ports and memory cycles leave bank_q unchanged.
- R5: Bank register fields: bits 2:0 are the RAM bank, bit 3 the character ROM select, bit 4 the colour plane select, bit 5 the dot clock select (1 = EGA rate), bit 7 the window enable. dot_ega follows bit 5.
- R6: A memory cycle (mreq high) with addr in F000h–FFFFh while bank bit 7 is set raises win_hit on the following clock, with vram_addr = {bank bits 2:0, addr[11:0]}.
- R7: A memory cycle below F000h, or any memory cycle while bank bit 7 is clear, gives win_hit, ram_en and xl_oe low on the following clock.
- R8: In output mode (xl_input_mode low), xl_oe and ram_en equal win_hit, and xl_out equals xl_drive_high whenever xl_oe is high.
- R9: In input mode (xl_input_mode high), xl_oe stays low and ram_en is high only when win_hit is high and xl_in was high at the same clock edge.
- R10: A memory cycle decodes against the bank register value held before the edge, so a register write at that same edge affects only later memory cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| iorq | input | 1 | I/O cycle strobe |
| mreq | input | 1 | Memory cycle strobe |
| wr | input | 1 | Write strobe |
| base_cfg | input | 6 | Port group base, compared with addr[7:2] |
| xl_input_mode | input | 1 | 1 = expansion line sampled, 0 = driven |
| xl_drive_high | input | 1 | Level driven in output mode |
| xl_in | input | 1 | Sampled expansion line |
| port_sel | output | 4 | One-hot selected port of the group |
| bank_q | output | 8 | Bank-select register |
| dot_ega | output | 1 | Dot clock select (1 = EGA rate) |
| win_hit | output | 1 | Memory cycle hit the open window |
| vram_addr | output | 15 | Video RAM address |
| ram_en | output | 1 | Video RAM enable |
| xl_out | output | 1 | Expansion line drive level |
| xl_oe | output | 1 | Expansion line output enable |

## Verification
A write to the bank register and a memory access to the window can meet at the same clock edge. That is the case where the window enable or the bank changes under an access. The bench forces it by asserting iorq, wr and mreq together, with a base-matched port-0 address whose top nibble is F. It then expects the window decision to follow the old register value while bank_q takes the new one. Random cycles also mix both strobes, and the bench model always decodes memory before it updates its register copy.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int unsigned IO_W       = 8;
  localparam int unsigned BF_BANK_LO = 0;
  localparam int unsigned BF_CHROM   = 3;
  localparam int unsigned BF_COLOUR  = 4;
  localparam int unsigned BF_DOT     = 5;
  localparam int unsigned BF_WIN_EN  = 7;

  typedef enum logic {XL_DRIVE = 1'b0, XL_SENSE = 1'b1} xl_mode_e;
endpackage

// File: rtl/vcd_port_match.sv
module vcd_port_match #(
  parameter int unsigned IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [vcd_pkg::IO_W-1:0]      io_addr,
  input  logic                          iorq,
  input  logic [vcd_pkg::IO_W-IDX_W-1:0] base_cfg,
  output logic [(1<<IDX_W)-1:0]         sel_now,
  output logic [(1<<IDX_W)-1:0]         sel_q
);
  localparam int unsigned NPORT = 1 << IDX_W;

  logic match;
  assign match = iorq && (io_addr[vcd_pkg::IO_W-1:IDX_W] == base_cfg);

  for (genvar g = 0; g < NPORT; g++) begin : g_sel
    assign sel_now[g] = match && (io_addr[IDX_W-1:0] == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_now;
  end

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  assert_no_sel_without_io_R3: assert property (@(posedge clk) disable iff (rst)
    !iorq |=> (sel_q == '0));
endmodule

// File: rtl/vcd_bank_reg.sv
module vcd_bank_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (rst)     bank_q <= '0;
    else if (we) bank_q <= wdata;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bank_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> (bank_q == $past(wdata)));
endmodule

// File: rtl/vcd_window.sv
module vcd_window #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_W  = 12,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    mreq,
  input  logic [DATA_W-1:0]       bank_q,
  input  vcd_pkg::xl_mode_e       xl_mode,
  input  logic                    xl_drive_high,
  input  logic                    xl_in,
  output logic                    win_hit,
  output logic [WIN_W+BANK_W-1:0] vram_addr,
  output logic                    ram_en,
  output logic                    xl_out,
  output logic                    xl_oe
);
  localparam int unsigned TAG_W = ADDR_W - WIN_W;

  logic in_win, hit_now, en_now;
  assign in_win  = (addr[ADDR_W-1:WIN_W] == {TAG_W{1'b1}});
  assign hit_now = mreq && in_win && bank_q[vcd_pkg::BF_WIN_EN];

  always_comb begin
    if (xl_mode == vcd_pkg::XL_SENSE) en_now = hit_now && xl_in;
    else                              en_now = hit_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_hit   <= 1'b0;
      ram_en    <= 1'b0;
      xl_oe     <= 1'b0;
      xl_out    <= 1'b0;
      vram_addr <= '0;
    end else begin
      win_hit   <= hit_now;
      ram_en    <= en_now;
      xl_oe     <= hit_now && (xl_mode == vcd_pkg::XL_DRIVE);
      xl_out    <= xl_drive_high;
      vram_addr <= {bank_q[vcd_pkg::BF_BANK_LO +: BANK_W], addr[WIN_W-1:0]};
    end
  end

  assert_hit_needs_mreq_R6: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(mreq));
  assert_oe_only_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
    xl_oe |-> win_hit);
  assert_sense_needs_line_R9: assert property (@(posedge clk) disable iff (rst)
    (ram_en && $past(xl_mode == vcd_pkg::XL_SENSE)) |-> $past(xl_in));
  assert_closed_window_R7: assert property (@(posedge clk) disable iff (rst)
    !bank_q[vcd_pkg::BF_WIN_EN] |=> !win_hit);
endmodule

// File: rtl/vidcard_bus_decode.sv
module vidcard_bus_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned WIN_W  = 12,
  parameter int unsigned BANK_W = 3,
  localparam int unsigned BASE_W = vcd_pkg::IO_W - IDX_W,
  localparam int unsigned NPORT  = 1 << IDX_W,
  localparam int unsigned VRAM_W = WIN_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iorq,
  input  logic              mreq,
  input  logic              wr,
  input  logic [BASE_W-1:0] base_cfg,
  input  logic              xl_input_mode,
  input  logic              xl_drive_high,
  input  logic              xl_in,
  output logic [NPORT-1:0]  port_sel,
  output logic [DATA_W-1:0] bank_q,
  output logic              dot_ega,
  output logic              win_hit,
  output logic [VRAM_W-1:0] vram_addr,
  output logic              ram_en,
  output logic              xl_out,
  output logic              xl_oe
);
  logic [NPORT-1:0] sel_now;
  logic             bank_we;
  vcd_pkg::xl_mode_e xl_mode;

  assign xl_mode = xl_input_mode ? vcd_pkg::XL_SENSE : vcd_pkg::XL_DRIVE;
  assign bank_we = wr && sel_now[0];
  assign dot_ega = bank_q[vcd_pkg::BF_DOT];

  vcd_port_match #(.IDX_W(IDX_W)) i_ports (
    .clk(clk), .rst(rst), .io_addr(addr[vcd_pkg::IO_W-1:0]), .iorq(iorq),
    .base_cfg(base_cfg), .sel_now(sel_now), .sel_q(port_sel)
  );

  vcd_bank_reg #(.DATA_W(DATA_W)) i_bank (
    .clk(clk), .rst(rst), .we(bank_we), .wdata(wdata), .bank_q(bank_q)
  );

  vcd_window #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) i_win (
    .clk(clk), .rst(rst), .addr(addr), .mreq(mreq), .bank_q(bank_q),
    .xl_mode(xl_mode), .xl_drive_high(xl_drive_high), .xl_in(xl_in),
    .win_hit(win_hit), .vram_addr(vram_addr), .ram_en(ram_en),
    .xl_out(xl_out), .xl_oe(xl_oe)
  );
endmodule

// File: tb/test_vidcard_bus_decode.sv
module test_vidcard_bus_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        iorq = 1'b0, mreq = 1'b0, wr = 1'b0;
  logic [5:0]  base_cfg = '0;
  logic        xl_input_mode = 1'b0, xl_drive_high = 1'b0, xl_in = 1'b0;
  logic [3:0]  port_sel;
  logic [7:0]  bank_q;
  logic        dot_ega, win_hit, ram_en, xl_out, xl_oe;
  logic [14:0] vram_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_bank = 8'h00;

  always #5 clk = ~clk;

  vidcard_bus_decode i_vidcard_bus_decode (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .iorq(iorq), .mreq(mreq),
    .wr(wr), .base_cfg(base_cfg), .xl_input_mode(xl_input_mode),
    .xl_drive_high(xl_drive_high), .xl_in(xl_in), .port_sel(port_sel),
    .bank_q(bank_q), .dot_ega(dot_ega), .win_hit(win_hit), .vram_addr(vram_addr),
    .ram_en(ram_en), .xl_out(xl_out), .xl_oe(xl_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] f_sel(input logic [15:0] a, input logic io, input logic [5:0] b);
    return (io && a[7:2] == b) ? (4'b0001 << a[1:0]) : 4'b0000;
  endfunction

  function automatic logic f_win(input logic [15:0] a, input logic m, input logic [7:0] bk);
    return m && (a[15:12] == 4'hF) && bk[7];
  endfunction

  // One bus cycle: inputs set at negedge, outputs sampled at the next negedge.
  task automatic cyc(input logic [15:0] a, input logic io, input logic m, input logic w,
                     input logic [7:0] d);
    logic [3:0] e_sel;
    logic       e_win, e_en, e_oe;
    logic [14:0] e_va;
    addr = a; iorq = io; mreq = m; wr = w; wdata = d;
    e_sel = f_sel(a, io, base_cfg);
    e_win = f_win(a, m, exp_bank);           // R10: decode uses pre-write value
    e_va  = {exp_bank[2:0], a[11:0]};
    e_en  = xl_input_mode ? (e_win && xl_in) : e_win;
    e_oe  = e_win && !xl_input_mode;
    if (io && w && e_sel[0]) exp_bank = d;
    @(posedge clk); @(negedge clk);
    chk(e_sel == 0 ? "R3 port_sel" : "R2 port_sel", port_sel, e_sel);
    chk("R4 bank_q", bank_q, exp_bank);
    chk("R5 dot_ega", dot_ega, exp_bank[5]);
    chk(e_win ? "R6 win_hit" : "R7 win_hit", win_hit, e_win);
    if (e_win) chk("R6 vram_addr", vram_addr, e_va);
    chk(xl_input_mode ? "R9 ram_en" : "R8 ram_en", ram_en, e_en);
    chk(xl_input_mode ? "R9 xl_oe" : "R8 xl_oe", xl_oe, e_oe);
    if (e_oe) chk("R8 xl_out", xl_out, xl_drive_high);
    iorq = 1'b0; mreq = 1'b0; wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] io_a;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while rst held
    chk("R1 bank_q", bank_q, 8'h00);
    chk("R1 port_sel", port_sel, 4'h0);
    chk("R1 win_hit", win_hit, 1'b0);
    chk("R1 ram_en", ram_en, 1'b0);
    chk("R1 xl_oe", xl_oe, 1'b0);
    rst = 1'b0;

    // R7: window closed after reset
    cyc(16'hF123, 1'b0, 1'b1, 1'b0, 8'h00);
    // R2/R3 at several bases, with upper address bits varied
    foreach (base_cfg[i]) begin end
    for (int b = 0; b < 4; b++) begin
      logic [5:0] bv;
      bv = (b == 0) ? 6'h00 : (b == 1) ? 6'h3F : (b == 2) ? 6'h15 : 6'h2A;
      base_cfg = bv;
      for (int k = 0; k < 4; k++) cyc({8'hA5 ^ 8'(k), bv, 2'(k)}, 1'b1, 1'b0, 1'b0, 8'h00);
      cyc({8'h00, bv ^ 6'h01, 2'b00}, 1'b1, 1'b0, 1'b0, 8'h00);
      cyc({8'h00, bv, 2'b00}, 1'b0, 1'b0, 1'b1, 8'hFF);
    end
    base_cfg = 6'h15;
    io_a = {8'h00, 6'h15, 2'b00};
    // R4: writes to other indices do not load
    cyc(io_a | 16'h0002, 1'b1, 1'b0, 1'b1, 8'hFF);
    cyc(io_a, 1'b1, 1'b0, 1'b0, 8'hFF);
    // open window, bank 5, EGA clock
    cyc(io_a, 1'b1, 1'b0, 1'b1, 8'hA5);
    // R6/R7 boundaries, output mode drive low and high
    xl_input_mode = 1'b0; xl_drive_high = 1'b0;
    cyc(16'hEFFF, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(16'hF000, 1'b0, 1'b1, 1'b0, 8'h00);
    xl_drive_high = 1'b1;
    cyc(16'hFFFF, 1'b0, 1'b1, 1'b0, 8'h00);
    cyc(16'h0000, 1'b0, 1'b1, 1'b0, 8'h00);
    // R9: input mode, line low then high
    xl_input_mode = 1'b1; xl_in = 1'b0;
    cyc(16'hF800, 1'b0, 1'b1, 1'b0, 8'h00);
    xl_in = 1'b1;
    cyc(16'hF800, 1'b0, 1'b1, 1'b0, 8'h00);
    // R10: write closing the window coincides with a window access
    xl_input_mode = 1'b0;
    cyc({4'hF, 4'h0, 6'h15, 2'b00}, 1'b1, 1'b1, 1'b1, 8'h02);
    cyc(16'hF010, 1'b0, 1'b1, 1'b0, 8'h00);
    // R10: write opening the window coincides with an access
    cyc({4'hF, 4'h3, 6'h15, 2'b00}, 1'b1, 1'b1, 1'b1, 8'h83);
    cyc(16'hF010, 1'b0, 1'b1, 1'b0, 8'h00);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic io, m, w;
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) base_cfg = 6'($urandom);
      xl_input_mode = r[4]; xl_drive_high = r[5]; xl_in = r[6];
      a = 16'($urandom);
      if (r[8:7] != 0) a[7:2] = base_cfg;
      if (r[10:9] != 0) a[15:12] = 4'hF;
      io = r[11] | r[12];
      m = r[13] | r[14];
      w = r[15];
      cyc(a, io, m, w, 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule